// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits between a byte-wide host write/read port and the control side of a flash core. It watches the byte writes the host issues, each carrying an 18-bit address and an 8-bit data value. It recognises the multi-write unlock sequences that guard every flash operation. When a sequence completes, it emits a single-cycle command to the core: program one byte, erase the whole chip, erase one sector, enter or leave the identification mode, or set the boot-block lockout. Program and sector-erase commands carry the address, and for program also the data, taken from the write that finished the sequence.

Every sequence opens with AA written to 05555h and then 55 written to 02AAAh. The third write, always to 05555h, chooses the branch. A0 arms a program, and the following write names the target byte. 90 enters identification mode. F0 leaves it. 80 opens the erase family, which repeats the AA/55 pair before a final write. That final write is 10 at 05555h for chip erase, 40 at 05555h for lockout, or 30 at any address for sector erase.

While identification mode is active, host reads of the three lowest addresses return identification bytes: a manufacturer code, a device code and the lockout flag. Writes that arrive while the core reports busy are ignored. Any write that does not fit the expected step returns the sequencer to its idle state without a command. The states are IDLE, GOT_AA (first unlock write seen), GOT_55 (second unlock write seen, awaiting the command byte), PROG_ARM (awaiting the program target), ERS_AA and ERS_55 (second unlock pair of the erase family) and ERS_CMD (awaiting the final erase-family byte).

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, cmd_valid is 0, cmd_op is 0 (none), id_mode is 0, the lockout flag is clear and the sequencer is in IDLE.
- R2: The writes AA@05555h, 55@02AAAh, A0@05555h followed by any write (A, D) raise cmd_valid for the clock after that fourth write, with cmd_op = 1 (program), cmd_addr = A and cmd_data = D.
- R3: The six writes AA@05555h, 55@02AAAh, 80@05555h, AA@05555h, 55@02AAAh, 10@05555h issue cmd_op = 2 (chip erase) in the clock after the sixth write.
- R4: The same five-write erase prefix followed by data 30 at any address S issues cmd_op = 3 (sector erase) with cmd_addr = S.
- R5: The erase prefix followed by 40@05555h issues cmd_op = 6 (lockout set) and sets a lockout flag that stays set until reset; the flag is read as bit 0 of the identification byte at address 00002h.
- R6: AA@05555h, 55@02AAAh, 90@05555h issues cmd_op = 4 (ID enter) and sets id_mode in the same clock; AA@05555h, 55@02AAAh, F0@05555h issues cmd_op = 5 (ID exit) and clears id_mode in the same clock.
- R7: With id_mode set, a read (rd_en high, wr_en low) raises id_rd_valid one clock later with id_rdata = MFR_CODE (default DAh) at 00000h, 32h at 00001h, {7'b0, lockout} at 00002h and 00h elsewhere; with id_mode clear, id_rd_valid stays 0.
- R8: A write whose address or data does not fit the current step returns the sequencer to IDLE with no command; continuing from where the broken sequence left off then issues nothing.
- R9: While core_busy is high, writes neither issue a command nor change the sequencer state; a sequence interrupted by busy writes resumes at the step it had reached.
- R10: cmd_valid is high for exactly one clock per completed sequence.
- R11: Any sixth erase-family byte other than 10@05555h, 40@05555h or 30@any returns to IDLE with no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe, one write per asserted clock |
| rd_en | input | 1 | Host read strobe (ignored when wr_en is high) |
| addr | input | 18 | Byte address of the write or read |
| wdata | input | 8 | Write data |
| core_busy | input | 1 | Core is executing an operation; writes are ignored |
| cmd_valid | output | 1 | One-clock command strobe to the core |
| cmd_op | output | 3 | Command code: 1 program, 2 chip erase, 3 sector erase, 4 ID enter, 5 ID exit, 6 lockout set |
| cmd_addr | output | 18 | Target byte or sector address |
| cmd_data | output | 8 | Byte to program |
| id_mode | output | 1 | Identification mode active |
| id_rd_valid | output | 1 | id_rdata holds an identification byte |
| id_rdata | output | 8 | Identification byte read data |

## Verification
The bench targets the places where a sequencer can silently go wrong. A wrong third byte or a wrong unlock address must reset the parse. A design that only held its state would let the tail of a broken sequence complete a program. Busy writes that land mid-sequence must be dropped without disturbing progress, since a design that advanced or reset on them would lose or fabricate a command. The erase family is driven to each of its three valid endings and to an invalid one, and the lockout flag is read back through identification reads, which also confirm that reads outside that mode return nothing.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int unsigned UNLK_ADDR_W = 16;
    localparam logic [UNLK_ADDR_W-1:0] UNLK_ADDR_FIRST  = 16'h5555;
    localparam logic [UNLK_ADDR_W-1:0] UNLK_ADDR_SECOND = 16'h2AAA;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_ERASE  = 8'h80;
    localparam logic [7:0] CODE_IDIN   = 8'h90;
    localparam logic [7:0] CODE_IDOUT  = 8'hF0;
    localparam logic [7:0] CODE_CHIP   = 8'h10;
    localparam logic [7:0] CODE_SECTOR = 8'h30;
    localparam logic [7:0] CODE_LOCK   = 8'h40;

    localparam logic [7:0] DEVICE_CODE = 8'h32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GOT_AA,
        S_GOT_55,
        S_PROG_ARM,
        S_ERS_AA,
        S_ERS_55,
        S_ERS_CMD
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_PROGRAM  = 3'd1,
        OP_CHIP_ERS = 3'd2,
        OP_SECT_ERS = 3'd3,
        OP_ID_ENTER = 3'd4,
        OP_ID_EXIT  = 3'd5,
        OP_LOCK_SET = 3'd6
    } cmd_op_t;

    typedef struct packed {
        logic at_first;
        logic at_second;
        logic is_aa;
        logic is_55;
        logic is_prog;
        logic is_erase;
        logic is_idin;
        logic is_idout;
        logic is_chip;
        logic is_sector;
        logic is_lock;
    } wr_match_t;

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
    import fcs_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output wr_match_t         match
);

    localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(UNLK_ADDR_FIRST);
    localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(UNLK_ADDR_SECOND);

    always_comb begin
        match.at_first  = (addr == A_FIRST);
        match.at_second = (addr == A_SECOND);
        match.is_aa     = (wdata == DATA_W'(KEY_FIRST));
        match.is_55     = (wdata == DATA_W'(KEY_SECOND));
        match.is_prog   = (wdata == DATA_W'(CODE_PROG));
        match.is_erase  = (wdata == DATA_W'(CODE_ERASE));
        match.is_idin   = (wdata == DATA_W'(CODE_IDIN));
        match.is_idout  = (wdata == DATA_W'(CODE_IDOUT));
        match.is_chip   = (wdata == DATA_W'(CODE_CHIP));
        match.is_sector = (wdata == DATA_W'(CODE_SECTOR));
        match.is_lock   = (wdata == DATA_W'(CODE_LOCK));
    end

endmodule

// File: rtl/fcs_fsm.sv
module fcs_fsm
    import fcs_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              core_busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  wr_match_t         match,
    output cmd_op_t           issue_op,
    output logic              cmd_valid,
    output cmd_op_t           cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       wr_take;
    logic       first_ok;
    logic       second_ok;

    assign wr_take   = wr_en && !core_busy;
    assign first_ok  = match.at_first && match.is_aa;
    assign second_ok = match.at_second && match.is_55;

    always_comb begin
        state_d  = state_q;
        issue_op = OP_NONE;
        if (wr_take) begin
            state_d = S_IDLE;
            unique case (state_q)
                S_IDLE: begin
                    if (first_ok) state_d = S_GOT_AA;
                end
                S_GOT_AA: begin
                    if (second_ok) state_d = S_GOT_55;
                end
                S_GOT_55: begin
                    if (match.at_first) begin
                        if (match.is_prog)       state_d  = S_PROG_ARM;
                        else if (match.is_erase) state_d  = S_ERS_AA;
                        else if (match.is_idin)  issue_op = OP_ID_ENTER;
                        else if (match.is_idout) issue_op = OP_ID_EXIT;
                    end
                end
                S_PROG_ARM: begin
                    issue_op = OP_PROGRAM;
                end
                S_ERS_AA: begin
                    if (first_ok) state_d = S_ERS_55;
                end
                S_ERS_55: begin
                    if (second_ok) state_d = S_ERS_CMD;
                end
                S_ERS_CMD: begin
                    if (match.is_sector)                     issue_op = OP_SECT_ERS;
                    else if (match.at_first && match.is_chip) issue_op = OP_CHIP_ERS;
                    else if (match.at_first && match.is_lock) issue_op = OP_LOCK_SET;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_op    <= OP_NONE;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= (issue_op != OP_NONE);
            cmd_op    <= issue_op;
            if (issue_op != OP_NONE) begin
                cmd_addr <= addr;
                cmd_data <= wdata;
            end
        end
    end

endmodule

// File: rtl/fcs_id_unit.sv
module fcs_id_unit
    import fcs_pkg::*;
#(
    parameter int unsigned ADDR_W   = 18,
    parameter int unsigned DATA_W   = 8,
    parameter logic [7:0]  MFR_CODE = 8'hDA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  cmd_op_t           issue_op,
    output logic              id_mode,
    output logic              lock_flag,
    output logic              id_rd_valid,
    output logic [DATA_W-1:0] id_rdata
);

    localparam logic [ADDR_W-1:0] ID_MFR_ADDR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ID_DEV_ADDR  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ID_LOCK_ADDR = ADDR_W'(2);

    logic [DATA_W-1:0] id_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_mode   <= 1'b0;
            lock_flag <= 1'b0;
        end else begin
            if (issue_op == OP_ID_ENTER)      id_mode <= 1'b1;
            else if (issue_op == OP_ID_EXIT)  id_mode <= 1'b0;
            if (issue_op == OP_LOCK_SET)      lock_flag <= 1'b1;
        end
    end

    always_comb begin
        unique case (addr)
            ID_MFR_ADDR:  id_byte = DATA_W'(MFR_CODE);
            ID_DEV_ADDR:  id_byte = DATA_W'(DEVICE_CODE);
            ID_LOCK_ADDR: id_byte = DATA_W'(lock_flag);
            default:      id_byte = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_rd_valid <= 1'b0;
            id_rdata    <= '0;
        end else if (rd_en && !wr_en && id_mode) begin
            id_rd_valid <= 1'b1;
            id_rdata    <= id_byte;
        end else begin
            id_rd_valid <= 1'b0;
            id_rdata    <= '0;
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int unsigned ADDR_W   = 18,
    parameter int unsigned DATA_W   = 8,
    parameter logic [7:0]  MFR_CODE = 8'hDA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              core_busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              id_mode,
    output logic              id_rd_valid,
    output logic [DATA_W-1:0] id_rdata
);

    wr_match_t match;
    cmd_op_t   issue_op;
    cmd_op_t   cmd_op_e;
    logic      lock_flag;

    fcs_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .addr  (addr),
        .wdata (wdata),
        .match (match)
    );

    fcs_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .core_busy (core_busy),
        .addr      (addr),
        .wdata     (wdata),
        .match     (match),
        .issue_op  (issue_op),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op_e),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    fcs_id_unit #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MFR_CODE (MFR_CODE)
    ) u_id (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .issue_op    (issue_op),
        .id_mode     (id_mode),
        .lock_flag   (lock_flag),
        .id_rd_valid (id_rd_valid),
        .id_rdata    (id_rdata)
    );

    assign cmd_op = cmd_op_e;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       core_busy,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       id_mode,
    input logic       id_rd_valid,
    input logic       lock_flag
);

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && core_busy) |=> (!cmd_valid && $stable(id_mode)));

    assert_cmd_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(wr_en) && !$past(core_busy)));

    assert_id_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> (cmd_valid && cmd_op == 3'd4));

    assert_id_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_mode) |-> (cmd_valid && cmd_op == 3'd5));

    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(lock_flag));

    assert_id_read_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        id_rd_valid |-> ($past(id_mode) && $past(rd_en) && !$past(wr_en)));

    assert_op_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op != 3'd0 && cmd_op != 3'd7));

endmodule

bind flash_cmd_seq fcs_checker u_fcs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .core_busy   (core_busy),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .id_mode     (id_mode),
    .id_rd_valid (id_rd_valid),
    .lock_flag   (lock_flag)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [17:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        core_busy = 1'b0;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [17:0] cmd_addr;
    logic [7:0]  cmd_data;
    logic        id_mode;
    logic        id_rd_valid;
    logic [7:0]  id_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .core_busy   (core_busy),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr),
        .cmd_data    (cmd_data),
        .id_mode     (id_mode),
        .id_rd_valid (id_rd_valid),
        .id_rdata    (id_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [17:0] a);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic unlock_pair();
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock_pair();
        wr(18'h05555, 8'h80);
        unlock_pair();
    endtask

    task automatic t_reset();
        chk("R1", "cmd_valid", 32'(cmd_valid), 0);
        chk("R1", "cmd_op", 32'(cmd_op), 0);
        chk("R1", "id_mode", 32'(id_mode), 0);
        chk("R1", "id_rd_valid", 32'(id_rd_valid), 0);
    endtask

    task automatic t_program();
        unlock_pair();
        wr(18'h05555, 8'hA0);
        chk("R2", "no cmd before target", 32'(cmd_valid), 0);
        wr(18'h12345, 8'h5A);
        chk("R2", "cmd_valid", 32'(cmd_valid), 1);
        chk("R2", "cmd_op", 32'(cmd_op), 1);
        chk("R2", "cmd_addr", 32'(cmd_addr), 32'h12345);
        chk("R2", "cmd_data", 32'(cmd_data), 32'h5A);
        @(posedge clk);
        #1;
        chk("R10", "pulse ends", 32'(cmd_valid), 0);
    endtask

    task automatic t_chip();
        erase_prefix();
        chk("R3", "no cmd before sixth", 32'(cmd_valid), 0);
        wr(18'h05555, 8'h10);
        chk("R3", "cmd_valid", 32'(cmd_valid), 1);
        chk("R3", "cmd_op", 32'(cmd_op), 2);
    endtask

    task automatic t_sector();
        erase_prefix();
        wr(18'h3C123, 8'h30);
        chk("R4", "cmd_valid", 32'(cmd_valid), 1);
        chk("R4", "cmd_op", 32'(cmd_op), 3);
        chk("R4", "cmd_addr", 32'(cmd_addr), 32'h3C123);
    endtask

    task automatic t_id_mode();
        unlock_pair();
        wr(18'h05555, 8'h90);
        chk("R6", "enter op", 32'(cmd_op), 4);
        chk("R6", "enter valid", 32'(cmd_valid), 1);
        chk("R6", "id_mode set", 32'(id_mode), 1);
        rd(18'h00000);
        chk("R7", "mfr valid", 32'(id_rd_valid), 1);
        chk("R7", "mfr byte", 32'(id_rdata), 32'hDA);
        rd(18'h00001);
        chk("R7", "device byte", 32'(id_rdata), 32'h32);
        rd(18'h00002);
        chk("R7", "lock byte clear", 32'(id_rdata), 0);
        rd(18'h00007);
        chk("R7", "other addr", 32'(id_rdata), 0);
        unlock_pair();
        wr(18'h05555, 8'hF0);
        chk("R6", "exit op", 32'(cmd_op), 5);
        chk("R6", "id_mode clear", 32'(id_mode), 0);
        rd(18'h00001);
        chk("R7", "no id read outside mode", 32'(id_rd_valid), 0);
    endtask

    task automatic t_lock();
        erase_prefix();
        wr(18'h05555, 8'h40);
        chk("R5", "cmd_valid", 32'(cmd_valid), 1);
        chk("R5", "cmd_op", 32'(cmd_op), 6);
        unlock_pair();
        wr(18'h05555, 8'h90);
        rd(18'h00002);
        chk("R5", "lock bit read", 32'(id_rdata), 1);
        unlock_pair();
        wr(18'h05555, 8'hF0);
    endtask

    task automatic t_mismatch();
        unlock_pair();
        wr(18'h05555, 8'h77);
        chk("R8", "bad code no cmd", 32'(cmd_valid), 0);
        wr(18'h05555, 8'hA0);
        wr(18'h00100, 8'h11);
        chk("R8", "tail after bad code", 32'(cmd_valid), 0);
        wr(18'h05555, 8'hAA);
        wr(18'h02AAB, 8'h55);
        wr(18'h05555, 8'hA0);
        wr(18'h00200, 8'h22);
        chk("R8", "bad address no cmd", 32'(cmd_valid), 0);
        unlock_pair();
        wr(18'h05555, 8'hA0);
        wr(18'h00300, 8'h33);
        chk("R8", "recovers after mismatch", 32'(cmd_op), 1);
    endtask

    task automatic t_bad_sixth();
        erase_prefix();
        wr(18'h05555, 8'h20);
        chk("R11", "bad sixth no cmd", 32'(cmd_valid), 0);
        wr(18'h05555, 8'h10);
        chk("R11", "returned to idle", 32'(cmd_valid), 0);
        erase_prefix();
        wr(18'h01234, 8'h10);
        chk("R11", "chip code off address", 32'(cmd_valid), 0);
    endtask

    task automatic t_busy();
        unlock_pair();
        core_busy = 1'b1;
        wr(18'h05555, 8'hAA);
        chk("R9", "busy write no cmd", 32'(cmd_valid), 0);
        wr(18'h05555, 8'hA0);
        @(negedge clk);
        core_busy = 1'b0;
        wr(18'h05555, 8'hA0);
        core_busy = 1'b1;
        wr(18'h0ABCD, 8'h99);
        chk("R9", "busy target ignored", 32'(cmd_valid), 0);
        @(negedge clk);
        core_busy = 1'b0;
        wr(18'h0ABCD, 8'h66);
        chk("R9", "resumed cmd_op", 32'(cmd_op), 1);
        chk("R9", "resumed data", 32'(cmd_data), 32'h66);
        chk("R9", "resumed addr", 32'(cmd_addr), 32'h0ABCD);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_program();
        t_chip();
        t_sector();
        t_id_mode();
        t_lock();
        t_mismatch();
        t_bad_sixth();
        t_busy();
        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule